// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a bus-mastering network controller. It walks a circular, linked list of receive descriptors kept in a word-addressed shared memory. Each descriptor is four 32-bit words. Offset 0 is the status word, offset 1 is the buffer word address, offset 2 is the buffer length in bytes, and offset 3 is the word address of the next descriptor. The engine fills only the descriptors it owns. It writes the arriving frame bytes into the buffer, then reports the stored length and the completion status. Writing the status word clears the ownership bit, which hands the descriptor back to the host. The engine then moves on to the next descriptor without further commands.

Before receive is started, the host loads the ring base into the current-descriptor register. It then issues one start command, which combines start and queue. If the engine fetches a descriptor that the host still owns, it parks in a stalled state and makes no memory accesses. It stays there until the host issues the next start command, which makes it fetch the same descriptor again. Frame bytes arrive on a valid/ready byte stream. The sender may hold a byte on the stream for as long as it needs. A byte moves only on a clock edge where both valid and ready are high. The engine raises ready only while it is filling an owned descriptor, so the stream is held back during descriptor fetch, writeback and stall. The memory port is a synchronous RAM with one cycle of read latency.

Top module: `rx_ring_engine`

## Requirements
- R1: While reset is asserted and after its release, until a start command is given, the engine makes no memory access and holds rx_ready and stalled low.
- R2: A start command in the idle or stalled state reads the four descriptor words at the current-descriptor address, at offsets 0, 1, 2 and 3 in that order.
- R3: Bit 31 of the status word set means the engine owns the descriptor. If a fetched descriptor has bit 31 clear, the engine raises stalled, keeps rx_ready low and makes no memory access until the next start command, which fetches the same descriptor again.
- R4: Stored byte k of a frame goes to word buffer+k/4, in bits 8*(k%4)+7 down to 8*(k%4) (little-endian packing). Each buffer word is written exactly once. The unused lanes of a final partial word are written as zero.
- R5: Bytes beyond the buffer length are accepted from the stream but dropped without any memory write. Such a frame sets status bit 13 (giant).
- R6: After the last byte, the engine writes the length word (offset 2) with the number of stored bytes. This count includes the 4 trailing frame check bytes exactly as received.
- R7: The status word (offset 0) is the last write for a frame. In it, bit 31 is clear, bit 13 is the giant flag, bits 2:1 are rx_err as sampled with the last byte, bit 0 is set only when the frame is neither giant nor errored, and all other bits are zero.
- R8: After writing the status word, the engine fetches the descriptor named by offset 3 without a new command. The ring therefore wraps at the entry that points back to the first.
- R9: rx_ready is high only while an owned descriptor is being filled. A byte transfers on an edge where rx_valid and rx_ready are both high. The byte with rx_last high ends the frame.
- R10: A current-descriptor write or a start command issued while the engine is fetching, receiving or writing back has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cda_we | input | 1 | Write strobe for the current-descriptor register |
| cda_wdata | input | AW | New current-descriptor word address |
| rx_start | input | 1 | Combined start-and-queue receive command |
| stalled | output | 1 | Engine is parked on a host-owned descriptor |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Engine accepts a stream byte |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 2 | Frame error flags, sampled with the last byte |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (otherwise read) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |

## Verification
The assertions assume three things about the inputs. The memory returns read data exactly one cycle after a read. The host never changes a descriptor that the engine currently owns. A start command is only meaningful while idle or stalled. The stimulus respects these assumptions. It sets the ownership bit of a descriptor only while the engine is stalled on that descriptor or has not yet reached it. It uses the memory model's fixed one-cycle read path. Start and register writes given during busy phases are used only to show that they are ignored. Stream bytes are offered with and without gaps. The error flags are driven only together with the final byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DESC_WORDS = 4;
  localparam int OFS_STAT   = 0;
  localparam int OFS_BUF    = 1;
  localparam int OFS_LEN    = 2;
  localparam int OFS_NEXT   = 3;
  localparam int OWN_BIT    = 31;
  localparam int GIANT_BIT  = 13;
  localparam int ERR_LSB    = 1;
  localparam int OK_BIT     = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STALL,
    ST_RECV,
    ST_WLEN,
    ST_WSTAT
  } rxr_state_e;
endpackage

// File: rtl/rxr_fetch.sv
module rxr_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          done,
  output logic [31:0]   w_stat,
  output logic [31:0]   w_buf,
  output logic [31:0]   w_len,
  output logic [31:0]   w_next
);
  import rxr_pkg::*;
  localparam int IW = $clog2(DESC_WORDS + 1);

  logic [IW-1:0] idx;
  logic          active;
  logic          done_q;
  logic [AW-1:0] base_q;
  logic [31:0]   words [DESC_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      active <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
        base_q <= base;
      end else if (active) begin
        if (idx != '0) words[2'(idx - IW'(1))] <= rd_data;
        if (idx == IW'(DESC_WORDS)) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end
        idx <= idx + IW'(1);
      end
    end
  end

  assign rd_en   = active && (idx < IW'(DESC_WORDS));
  assign rd_addr = base_q + AW'(idx);
  assign done    = done_q;
  assign w_stat  = words[OFS_STAT];
  assign w_buf   = words[OFS_BUF];
  assign w_len   = words[OFS_LEN];
  assign w_next  = words[OFS_NEXT];
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [AW-1:0] buf_base,
  input  logic [CW-1:0] buf_cap,
  input  logic          beat,
  input  logic [7:0]    beat_byte,
  input  logic          beat_last,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [CW-1:0] stored,
  output logic          overflow
);
  logic [CW-1:0] kept;
  logic [31:0]   acc;
  logic          giant;
  logic          room;
  logic [1:0]    lane;
  logic          at_cap;
  logic [31:0]   merged;

  assign room   = kept < buf_cap;
  assign lane   = kept[1:0];
  assign at_cap = (kept + CW'(1)) == buf_cap;

  always_comb begin
    merged = acc;
    merged[8*lane +: 8] = beat_byte;
  end

  assign wr_en   = beat && room && (lane == 2'd3 || beat_last || at_cap);
  assign wr_addr = buf_base + AW'(kept >> 2);
  assign wr_data = merged;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      kept  <= '0;
      acc   <= '0;
      giant <= 1'b0;
    end else if (beat) begin
      if (room) begin
        kept <= kept + CW'(1);
        acc  <= wr_en ? '0 : merged;
      end else begin
        giant <= 1'b1;
      end
    end
  end

  assign stored   = kept;
  assign overflow = giant;
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cda_we,
  input  logic [AW-1:0] cda_wdata,
  input  logic          rx_start,
  output logic          stalled,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [1:0]    rx_err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  import rxr_pkg::*;

  rxr_state_e    state, state_nx;
  logic [AW-1:0] cda;
  logic [1:0]    err_q;
  logic          host_ok;
  logic          fetch_go;
  logic [AW-1:0] fetch_base;
  logic          f_rd_en;
  logic [AW-1:0] f_rd_addr;
  logic          f_done;
  logic [31:0]   w_stat, w_buf, w_len, w_next;
  logic          owned;
  logic          pack_clear;
  logic          beat;
  logic          p_wr_en;
  logic [AW-1:0] p_wr_addr;
  logic [31:0]   p_wr_data;
  logic [CW-1:0] p_stored;
  logic          p_giant;
  logic [31:0]   stat_word;

  assign host_ok    = (state == ST_IDLE) || (state == ST_STALL);
  assign fetch_go   = (host_ok && rx_start) || (state == ST_WSTAT);
  assign fetch_base = (state == ST_WSTAT) ? AW'(w_next) : cda;
  assign owned      = w_stat[OWN_BIT];
  assign pack_clear = (state == ST_FETCH) && f_done && owned;
  assign rx_ready   = (state == ST_RECV);
  assign beat       = rx_ready && rx_valid;
  assign stalled    = (state == ST_STALL);

  rxr_fetch #(.AW(AW)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (fetch_go),
    .base    (fetch_base),
    .rd_en   (f_rd_en),
    .rd_addr (f_rd_addr),
    .rd_data (mem_rdata),
    .done    (f_done),
    .w_stat  (w_stat),
    .w_buf   (w_buf),
    .w_len   (w_len),
    .w_next  (w_next)
  );

  rxr_packer #(.AW(AW), .CW(CW)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pack_clear),
    .buf_base  (AW'(w_buf)),
    .buf_cap   (CW'(w_len)),
    .beat      (beat),
    .beat_byte (rx_data),
    .beat_last (rx_last),
    .wr_en     (p_wr_en),
    .wr_addr   (p_wr_addr),
    .wr_data   (p_wr_data),
    .stored    (p_stored),
    .overflow  (p_giant)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE, ST_STALL: if (rx_start) state_nx = ST_FETCH;
      ST_FETCH:          if (f_done) state_nx = owned ? ST_RECV : ST_STALL;
      ST_RECV:           if (beat && rx_last) state_nx = ST_WLEN;
      ST_WLEN:           state_nx = ST_WSTAT;
      ST_WSTAT:          state_nx = ST_FETCH;
      default:           state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cda   <= '0;
      err_q <= '0;
    end else begin
      state <= state_nx;
      if (host_ok && cda_we) cda <= cda_wdata;
      else if (state == ST_WSTAT) cda <= AW'(w_next);
      if (pack_clear) err_q <= '0;
      else if (beat && rx_last) err_q <= rx_err;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[GIANT_BIT] = p_giant;
    stat_word[ERR_LSB +: 2] = err_q;
    stat_word[OK_BIT] = !p_giant && (err_q == 2'b00);
  end

  always_comb begin
    mem_en    = f_rd_en;
    mem_we    = 1'b0;
    mem_addr  = f_rd_addr;
    mem_wdata = '0;
    if (p_wr_en) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = p_wr_addr;
      mem_wdata = p_wr_data;
    end else if (state == ST_WLEN) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = cda + AW'(OFS_LEN);
      mem_wdata = 32'(p_stored);
    end else if (state == ST_WSTAT) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = cda + AW'(OFS_STAT);
      mem_wdata = stat_word;
    end
  end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_start,
  input logic stalled,
  input logic rx_ready,
  input logic mem_en,
  input logic mem_we
);
  a_r3_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !mem_en);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !rx_start) |=> stalled);

  a_r9_ready_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !stalled);

  a_r9_no_read_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !(mem_en && !mem_we));

  a_r2_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  a_r3_restart_leaves_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && rx_start) |=> !stalled);
endmodule

bind rx_ring_engine rx_ring_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_start (rx_start),
  .stalled  (stalled),
  .rx_ready (rx_ready),
  .mem_en   (mem_en),
  .mem_we   (mem_we)
);

// File: tb/rx_ring_engine_test.sv
module rx_ring_engine_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cda_we = 1'b0;
  logic [AW-1:0] cda_wdata = '0;
  logic          rx_start = 1'b0;
  logic          stalled;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    rx_data = '0;
  logic          rx_last = 1'b0;
  logic [1:0]    rx_err = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  always #4 clk = ~clk;

  rx_ring_engine #(.AW(AW), .CW(16)) uut (
    .clk(clk), .rst_n(rst_n), .cda_we(cda_we), .cda_wdata(cda_wdata),
    .rx_start(rx_start), .stalled(stalled), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  typedef struct {
    logic [AW-1:0] a;
    logic [31:0]   d;
    string         req;
  } wr_item_t;

  wr_item_t      exp_q[$];
  logic [AW-1:0] rd_log[$];
  int            n_checks = 0;
  int            n_fails = 0;
  logic [7:0]    fbuf [64];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: compare every memory write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write", {16'h0, mem_addr}, 32'hx);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.a, {e.req, " addr"}, {16'h0, mem_addr}, {16'h0, e.a});
          chk(mem_wdata == e.d, {e.req, " data"}, mem_wdata, e.d);
        end
      end else begin
        rd_log.push_back(mem_addr);
      end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [31:0] d, input string req);
    wr_item_t e;
    e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // driver side: expected writes for one frame into one descriptor
  task automatic expect_frame(input int desc, input int bufa, input int cap,
                              input int n, input logic [1:0] err);
    int stored;
    logic [31:0] st;
    stored = (n < cap) ? n : cap;
    for (int w = 0; w < (stored + 3) / 4; w++) begin
      logic [31:0] word;
      word = '0;
      for (int l = 0; l < 4; l++)
        if (w * 4 + l < stored) word[8*l +: 8] = fbuf[w * 4 + l];
      push(AW'(bufa + w), word, (n > cap) ? "R5" : "R4");
    end
    push(AW'(desc + 2), 32'(stored), "R6");
    st = '0;
    st[13] = (n > cap);
    st[2:1] = err;
    st[0] = (n <= cap) && (err == 2'b00);
    push(AW'(desc), st, "R7");
  endtask

  task automatic send_frame(input int n, input logic [1:0] err, input bit gaps);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbuf[k];
      rx_last  = (k == n - 1);
      rx_err   = (k == n - 1) ? err : 2'b00;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
      rx_last  = 1'b0;
      rx_err   = 2'b00;
      if (gaps && (k % 3 == 1)) @(negedge clk);
    end
  endtask

  task automatic fill(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) fbuf[k] = seed + 8'(k * 7);
  endtask

  task automatic drain;
    for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
    chk(exp_q.size() == 0, "R7 writes outstanding", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic pulse_start;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // ring: 0x10 -> 0x20 -> 0x30 -> 0x10, own = bit 31
    mem[8'h10] = 32'h8000_0000; mem[8'h11] = 32'h80; mem[8'h12] = 32'd64; mem[8'h13] = 32'h20;
    mem[8'h20] = 32'h8000_0000; mem[8'h21] = 32'hA0; mem[8'h22] = 32'd10; mem[8'h23] = 32'h30;
    mem[8'h30] = 32'h8000_0000; mem[8'h31] = 32'hC0; mem[8'h32] = 32'd64; mem[8'h33] = 32'h10;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!rx_ready && !stalled && !mem_en, "R1 in reset", {rx_ready, stalled, mem_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rx_ready && !stalled && !mem_en, "R1 after reset", {rx_ready, stalled, mem_en}, 32'd0);

    @(negedge clk); cda_we = 1'b1; cda_wdata = 16'h10;
    @(negedge clk); cda_we = 1'b0;
    rd_log.delete();
    pulse_start();

    // frame 1: 12 bytes, fits, clean
    fill(12, 8'h11);
    expect_frame(16'h10, 16'h80, 64, 12, 2'b00);
    send_frame(12, 2'b00, 1'b0);
    // R10: busy-time register write and start are ignored
    cda_we = 1'b1; cda_wdata = 16'h55; rx_start = 1'b1;
    @(negedge clk); cda_we = 1'b0; rx_start = 1'b0;
    drain();
    chk(rd_log.size() >= 4, "R2 read count", 32'(rd_log.size()), 32'd4);
    for (int i = 0; i < 4; i++)
      if (i < rd_log.size())
        chk(rd_log[i] == AW'(16 + i), "R2 fetch order", {16'h0, rd_log[i]}, 32'(16 + i));

    // frame 2: 15 bytes into a 10-byte buffer, R5 truncation, with gaps
    fill(15, 8'h40);
    expect_frame(16'h20, 16'hA0, 10, 15, 2'b00);
    send_frame(15, 2'b00, 1'b1);
    drain();

    // frame 3: error flags, R7 and R10 (lands on 0x30 despite busy writes)
    fill(5, 8'hC3);
    expect_frame(16'h30, 16'hC0, 64, 5, 2'b10);
    send_frame(5, 2'b10, 1'b0);
    drain();

    // R3: descriptor 0x10 now host-owned, engine must stall quietly
    repeat (20) @(negedge clk);
    chk(stalled == 1'b1, "R3 stalled", {31'h0, stalled}, 32'd1);
    chk(rx_ready == 1'b0, "R3 not ready", {31'h0, rx_ready}, 32'd0);
    mem[8'h10] = 32'h8000_0000;
    repeat (5) @(negedge clk);
    chk(stalled == 1'b1, "R3 waits for start", {31'h0, stalled}, 32'd1);

    // R8: restart re-fetches and wraps to the first entry
    pulse_start();
    fill(7, 8'h5A);
    expect_frame(16'h10, 16'h80, 64, 7, 2'b00);
    send_frame(7, 2'b00, 1'b1);
    drain();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8 no extra writes", 32'(exp_q.size()), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule